// File: doc/BRIEF.md
# Fractional Clock Frequency Synthesizer

This block turns its input clock into a train of single-cycle enable pulses whose average rate is the input rate divided by twice a programmable division factor. The factor is an unsigned fixed-point number with 3 integer bits and 14 fractional bits. It lives in the low 17 bits of a 32-bit control word. When twice the factor is not a whole number of input cycles, a phase accumulator spreads the remainder across successive periods. Individual gaps then alternate between the two nearest whole cycle counts, and the long-run average stays exact.

Software programs the block through two write strobes. One replaces the entire control word. The other replaces only the 17-bit factor field and leaves the upper bits alone. The full word can always be read back. A factor of zero parks the output. A nonzero factor written while the output is parked starts the pulse train at once. A factor written while pulses are running waits for the next pulse boundary, so a period is never cut short or stretched. Downstream logic in the same clock domain uses the pulse as a clock enable.

Top module: `frac_clk_synth`

## Requirements
- R1: The division factor is the unsigned value in `ctrl_rdata[16:0]`. Bits 16..14 are the integer part and bits 13..0 are the fraction, so a raw value d stands for d/16384.
- R2: For a running raw factor d with 2d > 16384, every gap between consecutive `tick_out` pulses is c input cycles with |c*16384 - 2d| < 16384.
- R3: While the factor in effect is zero, `tick_out` stays low.
- R4: A `field_we` write changes only bits 16..0 of the control word. A `word_we` write loads all 32 bits. When both strobe in the same cycle, bits 16..0 come from `field_wdata` and bits 31..17 come from `word_wdata`.
- R5: Over any run of N consecutive gaps at a fixed factor d with 2d > 16384, the total cycle count T satisfies |T*16384 - N*2d| < 16384. The error does not grow with N.
- R6: When d is a whole multiple of 16384, every gap is exactly 2d/16384 cycles.
- R7: A new nonzero factor written while pulses run takes effect only after the next pulse. The gap that ends at that pulse follows the old factor, and the phase residue carries over into the new factor.
- R8: When 2d <= 16384 (factor at most 0.5), a pulse is produced on every input cycle and never more than one per cycle.
- R9: While `rst_n` is low at a rising edge, the control word and the accumulator clear. After that edge `ctrl_rdata` reads 0 and `tick_out` is low, and it stays low until a nonzero factor is written.
- R10: Suppose a nonzero factor d is written while the output is parked, committing at rising edge E. Let k = max(1, ceil(2d/16384)). The first pulse is registered at edge E+k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| word_we | input | 1 | Write strobe that loads the whole control word |
| word_wdata | input | 32 | Data for a whole-word write |
| field_we | input | 1 | Write strobe that loads only the division-factor field |
| field_wdata | input | 17 | New 3.14 division factor |
| ctrl_rdata | output | 32 | Current control word |
| tick_out | output | 1 | Single-cycle enable pulse at the synthesized rate |

## Verification
The bench aims at factors at or below 0.5 and at the single raw step just above 0.5. A design that clamped at the wrong threshold would skip cycles there, or its accumulator would run away. It also drives whole-number factors, where any off-by-one in the threshold compare shows up as a period one cycle too long on every gap. Cumulative spans over ten gaps expose a design that drops the residue on each pulse, because its average period drifts even though each single gap looks plausible. Mid-run factor changes, idle-start latency, and same-cycle word-and-field writes catch a design that applies a new factor at once, restarts the phase, or lets a field write disturb the upper control bits.

// File: rtl/fcs_pkg.sv
// Package: shared constants and types for the fractional clock synthesizer.
// Assumes: nothing; holds only default widths and the write-kind encoding.
package fcs_pkg;

    // Default field geometry: 3 integer bits, 14 fractional bits, 32-bit register.
    localparam int DEF_INT_W  = 3;
    localparam int DEF_FRAC_W = 14;
    localparam int DEF_REG_W  = 32;

    // Which write strobes fire in a cycle: bit 0 = whole word, bit 1 = factor field.
    typedef enum logic [1:0] {
        WR_NONE  = 2'b00,
        WR_WORD  = 2'b01,
        WR_FIELD = 2'b10,
        WR_BOTH  = 2'b11
    } wr_kind_e;

endpackage

// File: rtl/fcs_ctrl_reg.sv
// Module: control register holding the division factor in its low bits.
// Does: loads the full word or just the factor field. On a same-cycle
//       collision the field write wins the low bits.
// Assumes: REG_W > DIV_W; synchronous active-low reset clears the word.
module fcs_ctrl_reg
    import fcs_pkg::*;
#(
    parameter int REG_W = DEF_REG_W,
    parameter int DIV_W = DEF_INT_W + DEF_FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_we,
    input  logic [REG_W-1:0] word_wdata,
    input  logic             field_we,
    input  logic [DIV_W-1:0] field_wdata,
    output logic [REG_W-1:0] reg_q,
    output logic [DIV_W-1:0] div_field
);

    wr_kind_e         kind;
    logic [REG_W-1:0] reg_d;

    // Classify this cycle's write strobes.
    always_comb kind = wr_kind_e'({field_we, word_we});

    // Build the next register value from the write kind.
    always_comb begin
        reg_d = reg_q;
        case (kind)
            WR_WORD:  reg_d = word_wdata;
            WR_FIELD: reg_d = {reg_q[REG_W-1:DIV_W], field_wdata};
            WR_BOTH:  reg_d = {word_wdata[REG_W-1:DIV_W], field_wdata};
            default:  reg_d = reg_q;
        endcase
    end

    // Hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // Expose the factor field.
    always_comb div_field = reg_q[DIV_W-1:0];

    // A field-only write leaves the upper bits untouched.
    assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (field_we && !word_we) |=> $stable(reg_q[REG_W-1:DIV_W]));

    // Any field write lands in the factor field.
    assert_field_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        field_we |=> (div_field == $past(field_wdata)));

endmodule

// File: rtl/fcs_rate_sel.sv
// Module: selects the factor in effect and derives the period threshold.
// Does: copies the programmed factor into the active factor when idle or at
//       a pulse boundary, forms threshold 2*div in 2^-14 units, flags clamping.
// Assumes: boundary comes from the accumulator in the same cycle.
module fcs_rate_sel #(
    parameter int DIV_W  = 17,
    parameter int FRAC_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIV_W-1:0] div_field,
    input  logic           boundary,
    output logic [DIV_W:0] thr,
    output logic           running,
    output logic           clamp
);

    localparam int THR_W = DIV_W + 1;
    localparam logic [THR_W-1:0] UNIT = THR_W'(1) << FRAC_W;

    logic [DIV_W-1:0] act_div;

    // Adopt the programmed factor while parked or at each pulse boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                    act_div <= '0;
        else if (!running || boundary) act_div <= div_field;
    end

    // Threshold, run flag and clamp flag derived from the active factor.
    always_comb begin
        thr     = {act_div, 1'b0};
        running = |act_div;
        clamp   = running && (thr <= UNIT);
    end

    // Between boundaries the factor in effect must not move.
    assert_hold_until_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !boundary) |=> (thr == $past(thr)));

    // From the parked state a programmed factor is adopted on the next edge.
    assert_idle_adopt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (thr == {$past(div_field), 1'b0}));

endmodule

// File: rtl/fcs_phase_acc.sv
// Module: phase accumulator and pulse generator.
// Does: adds one cycle (2^FRAC_W) per clock and fires when the sum reaches
//       the threshold, keeping the residue. Clamped rates fire every cycle.
// Assumes: thr, running and clamp come from registers (no combinational loop).
module fcs_phase_acc #(
    parameter int THR_W  = 18,
    parameter int FRAC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr,
    input  logic             running,
    input  logic             clamp,
    output logic             boundary,
    output logic             pulse_q
);

    localparam logic [THR_W-1:0] UNIT = THR_W'(1) << FRAC_W;

    logic [THR_W-1:0] acc_q;
    logic [THR_W-1:0] acc_d;
    logic [THR_W:0]   sum_w;

    // Phase after this cycle's increment, one bit wider for the compare.
    always_comb sum_w = {1'b0, acc_q} + {1'b0, UNIT};

    // Fire when the period completes, or on every cycle when clamped.
    always_comb boundary = running && (clamp || (sum_w >= {1'b0, thr}));

    // Next phase: cleared when parked or clamped, residue kept on a boundary.
    always_comb begin
        if (!running || clamp) acc_d = '0;
        else if (boundary)     acc_d = acc_q + UNIT - thr;
        else                   acc_d = acc_q + UNIT;
    end

    // Phase and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            pulse_q <= boundary;
        end
    end

    // The stored phase stays below the threshold, so no period is skipped.
    assert_phase_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !clamp) |-> (acc_q < thr));

    // A parked synthesizer emits nothing on the next cycle.
    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !pulse_q);

    // A clamped rate pulses on every cycle.
    assert_clamp_every_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && clamp) |=> pulse_q);

endmodule

// File: rtl/frac_clk_synth.sv
// Module: fractional clock frequency synthesizer (top).
// Does: holds the control word and produces a single-cycle enable whose
//       average period is 2*div input cycles, div being unsigned 3.14.
// Assumes: one clock domain; synchronous active-low reset.
module frac_clk_synth
    import fcs_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int REG_W  = DEF_REG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_we,
    input  logic [REG_W-1:0]         word_wdata,
    input  logic                     field_we,
    input  logic [INT_W+FRAC_W-1:0]  field_wdata,
    output logic [REG_W-1:0]         ctrl_rdata,
    output logic                     tick_out
);

    localparam int DIV_W = INT_W + FRAC_W;
    localparam int THR_W = DIV_W + 1;

    logic [DIV_W-1:0] div_field;
    logic [THR_W-1:0] thr;
    logic             running;
    logic             clamp;
    logic             boundary;

    // Control word storage.
    fcs_ctrl_reg #(.REG_W(REG_W), .DIV_W(DIV_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (word_we),
        .word_wdata (word_wdata),
        .field_we   (field_we),
        .field_wdata(field_wdata),
        .reg_q      (ctrl_rdata),
        .div_field  (div_field)
    );

    // Active factor and threshold.
    fcs_rate_sel #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_field(div_field),
        .boundary (boundary),
        .thr      (thr),
        .running  (running),
        .clamp    (clamp)
    );

    // Phase accumulation and pulse output.
    fcs_phase_acc #(.THR_W(THR_W), .FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr     (thr),
        .running (running),
        .clamp   (clamp),
        .boundary(boundary),
        .pulse_q (tick_out)
    );

    // Reset leaves the word cleared and the output low.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> ((ctrl_rdata == '0) && !tick_out));

endmodule

// File: tb/sim_frac_clk_synth.sv
`timescale 1ns/1ps
module sim_frac_clk_synth;

    localparam longint UNIT = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_we = 1'b0;
    logic [31:0] word_wdata = '0;
    logic        field_we = 1'b0;
    logic [16:0] field_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        tick_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    frac_clk_synth u0 (
        .clk(clk), .rst_n(rst_n),
        .word_we(word_we), .word_wdata(word_wdata),
        .field_we(field_we), .field_wdata(field_wdata),
        .ctrl_rdata(ctrl_rdata), .tick_out(tick_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected register value after a write, from R4.
    function automatic logic [31:0] merge(input logic [31:0] old, input bit ww,
            input logic [31:0] w, input bit fw, input logic [16:0] f);
        logic [31:0] r;
        r = ww ? w : old;
        if (fw) r[16:0] = f;
        return r;
    endfunction

    // Gap rule from R2 / R8.
    function automatic bit gap_ok(input longint c, input longint d);
        if (2 * d <= UNIT) return c == 1;
        return (c * UNIT > 2 * d - UNIT) && (c * UNIT < 2 * d + UNIT);
    endfunction

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Called at a negedge; write commits at the next rising edge.
    task automatic wr_field(input logic [16:0] d);
        field_we = 1'b1; field_wdata = d;
        @(negedge clk);
        field_we = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w);
        word_we = 1'b1; word_wdata = w;
        @(negedge clk);
        word_we = 1'b0;
    endtask

    task automatic wr_both(input logic [31:0] w, input logic [16:0] d);
        word_we = 1'b1; word_wdata = w; field_we = 1'b1; field_wdata = d;
        @(negedge clk);
        word_we = 1'b0; field_we = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        int guard = 0;
        @(negedge clk);
        while (!tick_out && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        t = cyc;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick_out) cnt++;
        end
    endtask

    task automatic go_idle();
        int cnt;
        wr_field(17'd0);
        repeat (40) @(negedge clk);
        count_pulses(20, cnt);
        check(cnt == 0, "R3 parked output", cnt, 0);
    endtask

    // Run one factor from the parked state and check R1, R10, R2/R8, R6, R5.
    task automatic run_trial(input logic [16:0] d);
        int t_w, t0, tp, t;
        longint k;
        string gr;
        go_idle();
        wr_field(d);
        t_w = cyc;
        check(ctrl_rdata[16:0] == d, "R1 factor readback", ctrl_rdata[16:0], d);
        k = (2 * longint'(d) <= UNIT) ? 1 : (2 * longint'(d) + UNIT - 1) / UNIT;
        wait_pulse(t0);
        check((t0 - t_w) == k + 1, "R10 start latency", t0 - t_w, k + 1);
        gr = (2 * longint'(d) <= UNIT) ? "R8 clamped gap" : "R2 gap";
        tp = t0;
        for (int i = 0; i < 10; i++) begin
            wait_pulse(t);
            check(gap_ok(t - tp, d), gr, t - tp, (2 * longint'(d) + UNIT / 2) / UNIT);
            if (d % 17'(UNIT) == 0)
                check((t - tp) == 2 * longint'(d) / UNIT, "R6 whole period", t - tp, 2 * longint'(d) / UNIT);
            tp = t;
        end
        if (2 * longint'(d) > UNIT)
            check(labs(longint'(tp - t0) * UNIT - 20 * longint'(d)) < UNIT,
                  "R5 cumulative span", tp - t0, (20 * longint'(d)) / UNIT);
    endtask

    // Change factor mid-run right after a pulse (R7).
    task automatic change_trial(input logic [16:0] a, input logic [16:0] b);
        int tp, tq, t, tprev;
        longint expc;
        go_idle();
        wr_field(a);
        wait_pulse(tp);
        wait_pulse(tp);
        wr_field(b);
        wait_pulse(tq);
        check(gap_ok(tq - tp, a), "R7 old factor until boundary", tq - tp, (2 * longint'(a)) / UNIT);
        tprev = tq;
        for (int i = 0; i < 6; i++) begin
            wait_pulse(t);
            check(gap_ok(t - tprev, b), "R7 new factor gap", t - tprev, (2 * longint'(b)) / UNIT);
            tprev = t;
        end
        if (2 * longint'(b) > UNIT) begin
            expc = 2 * longint'(a) + 12 * longint'(b);
            check(labs(longint'(tprev - tp) * UNIT - expc) < UNIT,
                  "R7 residue carried", tprev - tp, expc / UNIT);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [31:0] expw;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check(ctrl_rdata == 32'd0, "R9 reset word", ctrl_rdata, 0);
        check(tick_out == 1'b0, "R9 reset output", tick_out, 0);
        rst_n = 1'b1;
        count_pulses(100, cnt);
        check(cnt == 0, "R3 zero factor after reset", cnt, 0);

        // Register write behaviour (R4).
        wr_word(32'hA5A5_0000);
        check(ctrl_rdata == 32'hA5A5_0000, "R4 word write", ctrl_rdata, 32'hA5A5_0000);
        expw = merge(ctrl_rdata, 1'b1, 32'h1234_5678, 1'b1, 17'd0);
        wr_both(32'h1234_5678, 17'd0);
        check(ctrl_rdata == expw, "R4 same-cycle writes", ctrl_rdata, expw);
        expw = merge(ctrl_rdata, 1'b0, 32'd0, 1'b1, 17'h0ABC);
        wr_field(17'h0ABC);
        check(ctrl_rdata == expw, "R4 field write keeps upper", ctrl_rdata, expw);
        check(ctrl_rdata[16:0] == 17'h0ABC, "R1 masked field", ctrl_rdata[16:0], 17'h0ABC);
        expw = merge(ctrl_rdata, 1'b0, 32'd0, 1'b1, 17'd0);
        go_idle();
        check(ctrl_rdata == expw, "R4 upper after park", ctrl_rdata, expw);

        // Directed factors.
        run_trial(17'd16384);
        run_trial(17'd32768);
        run_trial(17'd49152);
        run_trial(17'd114688);
        run_trial(17'd8192);
        run_trial(17'd4096);
        run_trial(17'd1);
        run_trial(17'd8193);
        run_trial(17'h1FFFF);
        run_trial(17'd24576);

        // Random factors.
        for (int i = 0; i < 15; i++) run_trial(17'($urandom_range(1, 131071)));

        // Mid-run changes.
        change_trial(17'd16384, 17'd40000);
        change_trial(17'd100000, 17'd4096);
        for (int i = 0; i < 6; i++)
            change_trial(17'($urandom_range(16384, 131071)), 17'($urandom_range(1, 131071)));

        // Reset while running (R9).
        go_idle();
        wr_word(32'hFFFE_0000);
        wr_field(17'd20000);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ctrl_rdata == 32'd0, "R9 mid-run reset word", ctrl_rdata, 0);
        check(tick_out == 1'b0, "R9 mid-run reset output", tick_out, 0);
        rst_n = 1'b1;
        count_pulses(50, cnt);
        check(cnt == 0, "R9 stays parked after reset", cnt, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule